// File: doc/BRIEF.md
# Translation Request Coalescer and Probe Issuer

This block sits in front of a downstream translation lookaside buffer. It merges address-translation requests into groups and sends one probe per group. Each request carries a virtual address, a read/write mode, a prefetch flag, an issue timestamp, a source ID and a count of the original requests it stands for. The timestamp, divided by a window length, picks a time bucket. Inside a bucket, a request joins an existing group whose leader is on the same virtual page and has the same mode. Otherwise it opens a new group with itself as leader.

An issue scan runs in the clock cycle after a request is accepted or after the downstream side signals a retry. The scan visits buckets from the smallest key upward and can send up to `LANES` group leaders in one cycle, one per output lane. A page that already has a translation in flight is held back. Groups in one bucket may overtake each other. A bucket that holds back or is refused anything ends the scan for that cycle, so later buckets wait. Each issued group leaves its bucket and its page is recorded in an outstanding table until a release names that page.

Top module: `tlb_coalescer`

## Requirements
- R1: A request joins an existing group only when its page number `req_vaddr[VA_W-1:PAGE_BITS]` equals the leader's and its `req_write` equals the leader's. The probe carries the leader's full address, mode and source.
- R2: The bucket key is `req_ts / WIN`. Requests with different keys never share a group, even on the same page.
- R3: A request that matches no group in its bucket, or finds no bucket with its key, opens a new group as leader in the lowest free group slot. If it needs a new bucket, that bucket is the lowest free one.
- R4: While `coalesce_off` is 1, every accepted request opens its own group.
- R5: A group's count starts at the leader's contribution and grows by each merging request's contribution. A contribution is `req_cnt`, with 0 read as 1, and a prefetch contributes 0.
- R6: At most `LANES` probes issue per scan. Probes fill lanes from lane 0 upward in scan order, which is bucket key ascending and then group slot ascending. The scan stops when all lanes are used.
- R7: A group whose page is in the outstanding table, or is issued earlier in the same scan, is held back. The scan still goes on to the later groups of the same bucket.
- R8: After a hold-back or a refusal (`dn_ready` = 0) in a bucket, no bucket with a larger key issues in that scan.
- R9: A scan happens only in the cycle after an accepted request or a `dn_retry` pulse. Its probes appear on `probe_valid` one clock edge after that cycle, for one cycle. Groups that are refused stay buffered until a later scan.
- R10: An issued group leaves its bucket, which becomes free once it has no groups. A `rel_valid` with `rel_vpage` removes that page from the outstanding table, so a later scan can issue a held group on that page.
- R11: `req_ready` is 0 when the matching group already holds `MEMBERS` requests. It is also 0 when no group matches and the bucket has no free group slot, or when the key is new and all `BUCKETS` buckets are in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| coalesce_off | input | 1 | 1 = no merging |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | Access mode, 1 = write |
| req_prefetch | input | 1 | Prefetch request |
| req_ts | input | TS_W | Issue timestamp |
| req_src | input | SRC_W | Source port ID |
| req_cnt | input | CNT_W | Original requests represented, 0 means 1 |
| dn_ready | input | 1 | Downstream accepts probes in this cycle |
| dn_retry | input | 1 | Downstream asks for a new scan |
| probe_valid | output | LANES | Probe present per lane |
| probe_vaddr | output | LANES*VA_W | Leader address per lane |
| probe_write | output | LANES | Leader mode per lane |
| probe_src | output | LANES*SRC_W | Leader source per lane |
| probe_cnt | output | LANES*CNT_W | Group count per lane |
| rel_valid | input | 1 | Release an outstanding page |
| rel_vpage | input | VA_W-PAGE_BITS | Page to release |

## Verification
A probe is due at the second falling edge after the clock edge that samples `dn_retry`. There is one edge to start the scan and one to register its lanes. The bench checks that `probe_valid` is still low at the first falling edge, then lets the monitor compare the lanes at the second. It checks again one edge later that the pulse has ended and that the scoreboard queue is empty. The bench drives requests while `dn_ready` is low, so the scans those requests start issue nothing. The bench therefore knows the full content of every bucket before it fires a retry, and it can predict each lane exactly.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
  typedef enum logic [1:0] {
    INS_JOIN = 2'd0,
    INS_OPEN = 2'd1,
    INS_NEWB = 2'd2
  } ins_t;
endpackage

// File: rtl/tlbc_rank.sv
module tlbc_rank #(
  parameter int NB    = 4,
  parameter int KEY_W = 16,
  parameter int BK_W  = 2
) (
  input  logic [NB-1:0]       bkt_v,
  input  logic [NB*KEY_W-1:0] bkt_key,
  output logic [NB*BK_W-1:0]  ord,
  output logic [NB-1:0]       ord_v
);
  always_comb begin
    int rk;
    rk = 0;
    ord = '0;
    ord_v = '0;
    for (int b = 0; b < NB; b++) begin
      rk = 0;
      for (int c = 0; c < NB; c++) begin
        if (c != b && bkt_v[c] &&
            bkt_key[c*KEY_W +: KEY_W] < bkt_key[b*KEY_W +: KEY_W])
          rk++;
      end
      if (bkt_v[b]) begin
        for (int r = 0; r < NB; r++) begin
          if (r == rk) begin
            ord[r*BK_W +: BK_W] = BK_W'(b);
            ord_v[r] = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tlbc_scan.sv
module tlbc_scan #(
  parameter int NB   = 4,
  parameter int NG   = 4,
  parameter int LIM  = 2,
  parameter int OT   = 8,
  parameter int PG_W = 20,
  parameter int BK_W = 2,
  parameter int GI_W = 4,
  parameter int FC_W = 4
) (
  input  logic                   scan_en,
  input  logic                   dn_ready,
  input  logic [NB*BK_W-1:0]     ord,
  input  logic [NB-1:0]          ord_v,
  input  logic [NB*NG-1:0]       g_v,
  input  logic [NB*NG*PG_W-1:0]  g_pg,
  input  logic [OT-1:0]          ot_v,
  input  logic [OT*PG_W-1:0]     ot_pg,
  input  logic [FC_W-1:0]        ot_free,
  output logic [NB*NG-1:0]       issue,
  output logic [LIM-1:0]         lane_v,
  output logic [LIM*GI_W-1:0]    lane_idx
);
  localparam int NGT = NB * NG;

  always_comb begin
    int  sent;
    int  bi;
    int  gi;
    logic stop;
    logic bblk;
    logic hit;
    sent = 0;
    bi = 0;
    gi = 0;
    stop = 1'b0;
    bblk = 1'b0;
    hit = 1'b0;
    issue = '0;
    lane_v = '0;
    lane_idx = '0;
    for (int r = 0; r < NB; r++) begin
      bblk = 1'b0;
      if (scan_en && ord_v[r] && !stop) begin
        bi = int'(ord[r*BK_W +: BK_W]);
        for (int g = 0; g < NG; g++) begin
          gi = bi * NG + g;
          if (g_v[gi] && !stop) begin
            hit = (sent >= int'(ot_free));
            for (int o = 0; o < OT; o++)
              if (ot_v[o] && ot_pg[o*PG_W +: PG_W] == g_pg[gi*PG_W +: PG_W])
                hit = 1'b1;
            for (int j = 0; j < NGT; j++)
              if (issue[j] && g_pg[j*PG_W +: PG_W] == g_pg[gi*PG_W +: PG_W])
                hit = 1'b1;
            if (hit || !dn_ready) begin
              bblk = 1'b1;
            end else begin
              issue[gi] = 1'b1;
              for (int l = 0; l < LIM; l++) begin
                if (l == sent) begin
                  lane_v[l] = 1'b1;
                  lane_idx[l*GI_W +: GI_W] = GI_W'(gi);
                end
              end
              sent++;
              if (sent == LIM) stop = 1'b1;
            end
          end
        end
        if (bblk) stop = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlbc_otable.sv
module tlbc_otable #(
  parameter int OT   = 8,
  parameter int LIM  = 2,
  parameter int PG_W = 20,
  parameter int FC_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LIM-1:0]      ins_v,
  input  logic [LIM*PG_W-1:0] ins_pg,
  input  logic                rel_v,
  input  logic [PG_W-1:0]     rel_pg,
  output logic [OT-1:0]       ot_v,
  output logic [OT*PG_W-1:0]  ot_pg,
  output logic [FC_W-1:0]     free_cnt
);
  localparam int OI_W = (OT > 1) ? $clog2(OT) : 1;

  logic [PG_W-1:0] pg_q [OT];
  logic [OI_W-1:0] slot [LIM];

  always_comb begin
    int k;
    k = 0;
    for (int l = 0; l < LIM; l++) slot[l] = '0;
    for (int o = 0; o < OT; o++) begin
      if (!ot_v[o]) begin
        for (int l = 0; l < LIM; l++)
          if (l == k) slot[l] = OI_W'(o);
        k++;
      end
    end
    free_cnt = FC_W'(k);
    for (int o = 0; o < OT; o++) ot_pg[o*PG_W +: PG_W] = pg_q[o];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ot_v <= '0;
    end else begin
      for (int o = 0; o < OT; o++)
        if (rel_v && ot_v[o] && pg_q[o] == rel_pg) ot_v[o] <= 1'b0;
      for (int l = 0; l < LIM; l++) begin
        if (ins_v[l]) begin
          ot_v[slot[l]] <= 1'b1;
          for (int o = 0; o < OT; o++)
            p_no_dup_page_r7: assert (!(ot_v[o] && pg_q[o] == ins_pg[l*PG_W +: PG_W]));
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LIM; l++)
      if (ins_v[l]) pg_q[slot[l]] <= ins_pg[l*PG_W +: PG_W];
  end
endmodule

// File: rtl/tlb_coalescer.sv
module tlb_coalescer #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int TS_W      = 16,
  parameter int WIN       = 4,
  parameter int SRC_W     = 3,
  parameter int CNT_W     = 8,
  parameter int BUCKETS   = 4,
  parameter int GROUPS    = 4,
  parameter int MEMBERS   = 8,
  parameter int LANES     = 2,
  parameter int OUTST     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        coalesce_off,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [VA_W-1:0]             req_vaddr,
  input  logic                        req_write,
  input  logic                        req_prefetch,
  input  logic [TS_W-1:0]             req_ts,
  input  logic [SRC_W-1:0]            req_src,
  input  logic [CNT_W-1:0]            req_cnt,
  input  logic                        dn_ready,
  input  logic                        dn_retry,
  output logic [LANES-1:0]            probe_valid,
  output logic [LANES*VA_W-1:0]       probe_vaddr,
  output logic [LANES-1:0]            probe_write,
  output logic [LANES*SRC_W-1:0]      probe_src,
  output logic [LANES*CNT_W-1:0]      probe_cnt,
  input  logic                        rel_valid,
  input  logic [VA_W-PAGE_BITS-1:0]   rel_vpage
);
  import tlbc_pkg::*;

  localparam int NB    = BUCKETS;
  localparam int NG    = GROUPS;
  localparam int NGT   = NB * NG;
  localparam int PG_W  = VA_W - PAGE_BITS;
  localparam int KEY_W = TS_W;
  localparam int BK_W  = (NB > 1) ? $clog2(NB) : 1;
  localparam int GI_W  = (NGT > 1) ? $clog2(NGT) : 1;
  localparam int MB_W  = $clog2(MEMBERS + 1);
  localparam int FC_W  = $clog2(OUTST + 1);

  // group storage
  logic [NGT-1:0]       g_v;
  logic [PG_W-1:0]      g_pg  [NGT];
  logic [PAGE_BITS-1:0] g_off [NGT];
  logic                 g_wr  [NGT];
  logic [SRC_W-1:0]     g_src [NGT];
  logic [CNT_W-1:0]     g_cnt [NGT];
  logic [MB_W-1:0]      g_mem [NGT];
  logic [KEY_W-1:0]     bkt_key [NB];
  logic                 scan_pend;

  logic [NB-1:0]        bkt_v;
  logic [NB*KEY_W-1:0]  bkt_key_flat;
  logic [NGT*PG_W-1:0]  g_pg_flat;
  logic [NB*BK_W-1:0]   ord;
  logic [NB-1:0]        ord_v;
  logic [NGT-1:0]       issue;
  logic [LANES-1:0]     lane_v;
  logic [LANES*GI_W-1:0] lane_idx;
  logic [OUTST-1:0]     ot_v;
  logic [OUTST*PG_W-1:0] ot_pg;
  logic [FC_W-1:0]      ot_free;
  logic [LANES*PG_W-1:0] ins_pg;

  logic [PG_W-1:0]      req_pg;
  logic [KEY_W-1:0]     req_key;
  logic [CNT_W-1:0]     add;
  logic                 fire;

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      bkt_v[b] = |g_v[b*NG +: NG];
      bkt_key_flat[b*KEY_W +: KEY_W] = bkt_key[b];
    end
    for (int i = 0; i < NGT; i++) g_pg_flat[i*PG_W +: PG_W] = g_pg[i];
    for (int l = 0; l < LANES; l++)
      ins_pg[l*PG_W +: PG_W] = g_pg[lane_idx[l*GI_W +: GI_W]];
  end

  tlbc_rank #(.NB(NB), .KEY_W(KEY_W), .BK_W(BK_W)) u_rank (
    .bkt_v(bkt_v), .bkt_key(bkt_key_flat), .ord(ord), .ord_v(ord_v)
  );

  tlbc_scan #(.NB(NB), .NG(NG), .LIM(LANES), .OT(OUTST), .PG_W(PG_W),
              .BK_W(BK_W), .GI_W(GI_W), .FC_W(FC_W)) u_scan (
    .scan_en(scan_pend), .dn_ready(dn_ready), .ord(ord), .ord_v(ord_v),
    .g_v(g_v), .g_pg(g_pg_flat), .ot_v(ot_v), .ot_pg(ot_pg),
    .ot_free(ot_free), .issue(issue), .lane_v(lane_v), .lane_idx(lane_idx)
  );

  tlbc_otable #(.OT(OUTST), .LIM(LANES), .PG_W(PG_W), .FC_W(FC_W)) u_otab (
    .clk(clk), .rst(rst), .ins_v(lane_v), .ins_pg(ins_pg),
    .rel_v(rel_valid), .rel_pg(rel_vpage), .ot_v(ot_v), .ot_pg(ot_pg),
    .free_cnt(ot_free)
  );

  assign req_pg  = req_vaddr[VA_W-1:PAGE_BITS];
  assign req_key = req_ts / KEY_W'(WIN);
  assign add     = req_prefetch ? '0 : ((req_cnt == '0) ? CNT_W'(1) : req_cnt);
  assign fire    = req_valid && req_ready;

  // acceptance, judged on the state before this cycle's issue
  always_comb begin
    logic any_m, all_ok, bh, bfree_g, bfree;
    int gi;
    any_m = 1'b0; all_ok = 1'b1; bh = 1'b0; bfree_g = 1'b0; bfree = 1'b0;
    gi = 0;
    for (int b = 0; b < NB; b++) begin
      if (!bkt_v[b]) bfree = 1'b1;
      if (bkt_v[b] && bkt_key[b] == req_key) begin
        bh = 1'b1;
        for (int g = 0; g < NG; g++) begin
          gi = b * NG + g;
          if (!g_v[gi]) bfree_g = 1'b1;
          else if (!coalesce_off && g_pg[gi] == req_pg && g_wr[gi] == req_write) begin
            any_m = 1'b1;
            if (g_mem[gi] >= MB_W'(MEMBERS)) all_ok = 1'b0;
          end
        end
      end
    end
    req_ready = any_m ? all_ok : (bh ? bfree_g : bfree);
  end

  // placement, judged on the state after this cycle's issue
  logic [NGT-1:0] gv_post;
  logic [NB-1:0]  bv_post;
  ins_t           act;
  logic [GI_W-1:0] tgt;
  logic [BK_W-1:0] nb_i;

  always_comb begin
    logic ph, pm, ps, nbf;
    int ph_b, pm_i, ps_i, gi;
    ph = 1'b0; pm = 1'b0; ps = 1'b0; nbf = 1'b0;
    ph_b = 0; pm_i = 0; ps_i = 0; gi = 0;
    nb_i = '0;
    gv_post = g_v & ~issue;
    for (int b = 0; b < NB; b++) bv_post[b] = |gv_post[b*NG +: NG];
    for (int b = 0; b < NB; b++) begin
      if (bv_post[b] && bkt_key[b] == req_key && !ph) begin
        ph = 1'b1;
        ph_b = b;
      end
      if (!bv_post[b] && !nbf) begin
        nbf = 1'b1;
        nb_i = BK_W'(b);
      end
    end
    if (ph) begin
      for (int g = 0; g < NG; g++) begin
        gi = ph_b * NG + g;
        if (gv_post[gi] && !pm && !coalesce_off &&
            g_pg[gi] == req_pg && g_wr[gi] == req_write) begin
          pm = 1'b1;
          pm_i = gi;
        end
        if (!gv_post[gi] && !ps) begin
          ps = 1'b1;
          ps_i = gi;
        end
      end
    end
    if (pm) begin
      act = INS_JOIN;
      tgt = GI_W'(pm_i);
    end else if (ph) begin
      act = INS_OPEN;
      tgt = GI_W'(ps_i);
    end else begin
      act = INS_NEWB;
      tgt = GI_W'(int'(nb_i) * NG);
    end
  end

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      g_v         <= '0;
      scan_pend   <= 1'b0;
      probe_valid <= '0;
    end else begin
      scan_pend   <= fire | dn_retry;
      probe_valid <= lane_v;
      g_v         <= gv_post;
      if (fire && act != INS_JOIN) g_v[tgt] <= 1'b1;
      if (fire && act == INS_JOIN)
        p_no_overflow_r11: assert (g_mem[tgt] < MB_W'(MEMBERS));
    end
  end

  // data storage, no reset
  always_ff @(posedge clk) begin
    if (fire) begin
      if (act == INS_JOIN) begin
        g_cnt[tgt] <= g_cnt[tgt] + add;
        g_mem[tgt] <= g_mem[tgt] + MB_W'(1);
      end else begin
        g_pg[tgt]  <= req_pg;
        g_off[tgt] <= req_vaddr[PAGE_BITS-1:0];
        g_wr[tgt]  <= req_write;
        g_src[tgt] <= req_src;
        g_cnt[tgt] <= add;
        g_mem[tgt] <= MB_W'(1);
        if (act == INS_NEWB) bkt_key[nb_i] <= req_key;
      end
    end
    for (int l = 0; l < LANES; l++) begin
      probe_vaddr[l*VA_W +: VA_W]   <= {g_pg[lane_idx[l*GI_W +: GI_W]],
                                        g_off[lane_idx[l*GI_W +: GI_W]]};
      probe_write[l]                <= g_wr[lane_idx[l*GI_W +: GI_W]];
      probe_src[l*SRC_W +: SRC_W]   <= g_src[lane_idx[l*GI_W +: GI_W]];
      probe_cnt[l*CNT_W +: CNT_W]   <= g_cnt[lane_idx[l*GI_W +: GI_W]];
    end
  end

  p_scan_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (|probe_valid) |-> $past(scan_pend && dn_ready));

  for (genvar l = 1; l < LANES; l++) begin : g_lane_chk
    p_lanes_packed_r6: assert property (@(posedge clk) disable iff (rst)
      probe_valid[l] |-> probe_valid[l-1]);
  end
endmodule

// File: tb/sim_tlb_coalescer.sv
module sim_tlb_coalescer;
  localparam int CLK_P = 10;
  localparam int VA_W = 32, PB = 12, TS_W = 16, SRC_W = 3, CNT_W = 8, LN = 2;

  logic clk = 1'b0, rst = 1'b1, coalesce_off = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_prefetch = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic [TS_W-1:0] req_ts = '0;
  logic [SRC_W-1:0] req_src = '0;
  logic [CNT_W-1:0] req_cnt = '0;
  logic dn_ready = 1'b0, dn_retry = 1'b0, rel_valid = 1'b0;
  logic [VA_W-PB-1:0] rel_vpage = '0;
  logic req_ready;
  logic [LN-1:0] probe_valid, probe_write;
  logic [LN*VA_W-1:0] probe_vaddr;
  logic [LN*SRC_W-1:0] probe_src;
  logic [LN*CNT_W-1:0] probe_cnt;

  tlb_coalescer u0 (
    .clk(clk), .rst(rst), .coalesce_off(coalesce_off), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .req_prefetch(req_prefetch), .req_ts(req_ts), .req_src(req_src),
    .req_cnt(req_cnt), .dn_ready(dn_ready), .dn_retry(dn_retry),
    .probe_valid(probe_valid), .probe_vaddr(probe_vaddr),
    .probe_write(probe_write), .probe_src(probe_src), .probe_cnt(probe_cnt),
    .rel_valid(rel_valid), .rel_vpage(rel_vpage)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    logic [VA_W-1:0] va;
    logic wr;
    int src;
    int cnt;
    int lane;
    string tag;
  } exp_t;

  exp_t q[$];
  exp_t me;
  int nchk = 0, nerr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int l = 0; l < LN; l++) begin
        if (probe_valid[l]) begin
          nchk++;
          if (q.size() == 0) begin
            nerr++;
            $display("FAIL R9 unexpected probe lane %0d: actual va=%h expected none",
                     l, probe_vaddr[l*VA_W +: VA_W]);
          end else begin
            me = q.pop_front();
            if (probe_vaddr[l*VA_W +: VA_W] != me.va || probe_write[l] != me.wr ||
                int'(probe_src[l*SRC_W +: SRC_W]) != me.src ||
                int'(probe_cnt[l*CNT_W +: CNT_W]) != me.cnt || l != me.lane) begin
              nerr++;
              $display("FAIL %s: actual va=%h wr=%0d src=%0d cnt=%0d lane=%0d expected va=%h wr=%0d src=%0d cnt=%0d lane=%0d",
                       me.tag, probe_vaddr[l*VA_W +: VA_W], probe_write[l],
                       probe_src[l*SRC_W +: SRC_W], probe_cnt[l*CNT_W +: CNT_W], l,
                       me.va, me.wr, me.src, me.cnt, me.lane);
            end
          end
        end
      end
    end
  end

  task automatic expect_p(input logic [VA_W-1:0] va, input logic wr, input int src,
                          input int cnt, input int lane, input string tag);
    exp_t e;
    e.va = va; e.wr = wr; e.src = src; e.cnt = cnt; e.lane = lane; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic send(input logic [VA_W-1:0] va, input logic wr, input logic pf,
                      input int ts, input int cnt, input int src);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = wr; req_prefetch = pf;
    req_ts = TS_W'(ts); req_cnt = CNT_W'(cnt); req_src = SRC_W'(src);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic peek_ready(input logic [VA_W-1:0] va, input int ts, input int exp,
                            input string tag);
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = va; req_write = 1'b0; req_prefetch = 1'b0;
    req_ts = TS_W'(ts); req_cnt = 8'd1;
    #1;
    chk(tag, int'(req_ready), exp);
  endtask

  task automatic retry(input logic rdy, input string tag);
    @(negedge clk);
    dn_retry = 1'b1; dn_ready = rdy;
    @(negedge clk);
    dn_retry = 1'b0;
    chk({tag, " R9 no probe before due edge"}, int'(probe_valid), 0);
    @(negedge clk);
    dn_ready = 1'b0;
    @(negedge clk);
    chk({tag, " R9 probe pulse ended"}, int'(probe_valid), 0);
    chk({tag, " R9 all expected probes seen"}, q.size(), 0);
  endtask

  task automatic release_pg(input int pg);
    @(negedge clk);
    rel_valid = 1'b1; rel_vpage = (VA_W-PB)'(pg);
    @(negedge clk);
    rel_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset probe_valid", int'(probe_valid), 0);
    chk("reset R11 req_ready", int'(req_ready), 1);

    // merge, mode split, counts, refusal kept
    send(32'h5010, 0, 0, 0, 1, 1);
    send(32'h5FF0, 0, 0, 3, 2, 2);
    send(32'h5020, 1, 0, 1, 0, 3);
    send(32'h5030, 0, 1, 2, 3, 4);
    retry(1'b0, "R9 refused");
    expect_p(32'h5010, 0, 1, 3, 0, "R1 R5 merged read group");
    retry(1'b1, "R7 same page in scan");
    release_pg(5);
    expect_p(32'h5020, 1, 3, 1, 0, "R10 R5 write group after release");
    retry(1'b1, "R10 release");
    release_pg(5);

    // windows, ordering, overtake
    send(32'h7100, 0, 0, 9, 1, 1);
    send(32'h9000, 0, 0, 10, 1, 2);
    send(32'h7004, 0, 0, 4, 1, 3);
    send(32'h8000, 0, 0, 7, 1, 4);
    expect_p(32'h7004, 0, 3, 1, 0, "R8 R2 smallest key first lane0");
    expect_p(32'h8000, 0, 4, 1, 1, "R6 second lane");
    retry(1'b1, "R6 lane limit");
    expect_p(32'h9000, 0, 2, 1, 0, "R7 overtake blocked group");
    retry(1'b1, "R7 overtake");
    release_pg(7);
    expect_p(32'h7100, 0, 1, 1, 0, "R2 same page other window");
    retry(1'b1, "R2 window");
    release_pg(7); release_pg(8); release_pg(9);

    // block stops later buckets
    send(32'h14000, 0, 0, 12, 1, 5);
    expect_p(32'h14000, 0, 5, 1, 0, "R3 lone leader");
    retry(1'b1, "R3");
    send(32'h14008, 0, 0, 16, 1, 6);
    send(32'h15000, 0, 0, 20, 1, 7);
    retry(1'b1, "R8 later bucket held");
    release_pg(20);
    expect_p(32'h14008, 0, 6, 1, 0, "R8 released bucket");
    expect_p(32'h15000, 0, 7, 1, 1, "R8 later bucket follows");
    retry(1'b1, "R8 resume");
    release_pg(20); release_pg(21);

    // no merging
    coalesce_off = 1'b1;
    send(32'h1E000, 0, 0, 24, 1, 1);
    send(32'h1E040, 0, 0, 25, 1, 2);
    expect_p(32'h1E000, 0, 1, 1, 0, "R4 first own group");
    retry(1'b1, "R4");
    release_pg(30);
    expect_p(32'h1E040, 0, 2, 1, 0, "R4 second own group");
    retry(1'b1, "R4 second");
    release_pg(30);
    coalesce_off = 1'b0;

    // backpressure
    for (int i = 0; i < 8; i++) send(32'h28000 + 32'(i*16), 0, 0, 40, 1, 1);
    peek_ready(32'h28100, 41, 0, "R11 full group");
    peek_ready(32'h29000, 41, 1, "R11 free group slot");
    send(32'h2A000, 0, 0, 44, 1, 2);
    send(32'h2B000, 0, 0, 48, 1, 3);
    send(32'h2C000, 0, 0, 52, 1, 4);
    peek_ready(32'h2D000, 56, 0, "R11 no free bucket");
    peek_ready(32'h2E000, 45, 1, "R11 existing bucket slot");
    expect_p(32'h28000, 0, 1, 8, 0, "R5 eight members");
    expect_p(32'h2A000, 0, 2, 1, 1, "R6 key11");
    retry(1'b1, "R11 drain a");
    expect_p(32'h2B000, 0, 3, 1, 0, "R10 key12");
    expect_p(32'h2C000, 0, 4, 1, 1, "R10 key13");
    retry(1'b1, "R11 drain b");
    peek_ready(32'h2D000, 56, 1, "R10 buckets freed");
    release_pg(40); release_pg(42); release_pg(43); release_pg(44);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule